// File: doc/BRIEF.md
# Translation Unit Control and Fault Interrupt Registers

This block is the software-visible control face of a small I/O address-translation unit. A host reaches it through a 32-bit word bus with a request valid/ready handshake, covering a 256-byte window. Through it the host reads a fixed revision word and sets idle behaviour and the translation, table-walk and emulator-lookup enables. It also programs the base of the translation table and services faults. The TLB and the walker are not part of the block: they send one-cycle fault pulses and a faulting virtual address in, and they take the enable levels out.

Fault pulses collect in sticky status bits that are cleared by writing ones. The interrupt line is the OR of the status bits whose enable is set. The address of the first enabled fault is held until software has cleared every enabled pending bit. A self-clearing soft-reset command brings every register back to its reset state over a fixed number of cycles. The bus stalls for that time, and a done flag then reads back as set.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. A write takes effect at that edge. A read returns `rsp_valid` with `rsp_rdata` exactly one cycle later. The response has no ready, so the host must take it in that cycle. `req_ready` is low only while a soft reset runs. A host holding `req_valid` keeps its request stable until it is taken.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: A request is accepted on an edge with req_valid and req_ready high. An accepted read gives rsp_valid high for exactly the next cycle, carrying the addressed word. rsp_valid is low in every other cycle.
- R2: Word offset 0x00 always reads 0x00000011: major version 1 in bits 7:4 and minor version 1 in bits 3:0. Writes to it have no effect.
- R3: Offset 0x10 holds autoidle in bit 0 and idle mode in bits 4:3 (0 force, 1 none, 2 smart, 3 stored as written). Both drive the autoidle and idle_mode outputs. All other bits read 0, and the reset value is 0.
- R4: Offset 0x44 holds translation enable in bit 1, table-walk enable in bit 2 and emulator-lookup enable in bit 3. These drive xlat_en, walk_en and emu_tlb_en. Bit 0 and bits 31:4 read 0, and the reset value is 0.
- R5: Offset 0x4C holds a table base in bits 31:14. A write with any of bits 13:0 set is discarded and leaves the old value. Bits 13:0 always read 0, and the reset value is 0.
- R6: A pulse on fault_pulse bit i sets status bit i at offset 0x18, whether or not it is enabled. The sources are: bit 0 TLB miss, bit 1 translation fault, bit 2 emulator miss, bit 3 table-walk fault, bit 4 multi-hit. A status bit stays set until a write with a 1 in that position. Zeros written leave bits alone. A pulse in the same cycle as the clearing write keeps the bit set.
- R7: Offset 0x1C bits 4:0 are the interrupt enables and read back as written. irq is high in the cycle after an edge that leaves any status bit set whose enable is set, and low otherwise.
- R8: fault_va is captured into the register at offset 0x48 on an edge where an enabled fault pulses and no enabled status bit remains pending after that edge's clearing write. Otherwise the register is kept. Faults on disabled sources never capture.
- R9: Writing offset 0x10 with bit 1 set starts a soft reset and discards the other bits of that write. req_ready stays low for exactly RST_CYCLES cycles. Afterwards all registers hold their reset values and bit 1 of offset 0x10 reads 0.
- R10: Offset 0x14 bit 0 reads 1 after hardware reset and after a soft reset completes. All other bits read 0, and writes have no effect.
- R11: Fault pulses that arrive while a soft reset runs are discarded: status reads 0 and irq is low afterwards.
- R12: Offsets with no register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can accept a request (low during soft reset) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 6 | Word address, byte address bits 7:2 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after accept |
| rsp_rdata | output | 32 | Read data |
| fault_pulse | input | 5 | One-cycle fault events from the translation path |
| fault_va | input | VA_W | Virtual address of the current fault |
| irq | output | 1 | Level interrupt |
| xlat_en | output | 1 | Translation enable |
| walk_en | output | 1 | Table-walk enable |
| emu_tlb_en | output | 1 | Emulator-lookup enable |
| idle_mode | output | 2 | Idle mode selection |
| autoidle | output | 1 | Autoidle enable |

## Verification
A wrong status or enable bit shows on irq at the next sampling point after the pulse or the write that caused it, and on the status readback one cycle after the read is taken. A capture that fires when it should not, or misses when it should, shows only when offset 0x48 is next read. The bench therefore reads it back after every fault pattern that matters. A miscounted reset sequencer shows as a req_ready low window of the wrong length, or as registers that are not zero when the bus reopens.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned WIN_BYTES    = 256;
  localparam int unsigned IDX_W        = $clog2(WIN_BYTES) - 2;
  localparam int unsigned NUM_FAULT    = 5;
  localparam int unsigned BASE_ALIGN_W = 14;

  typedef logic [IDX_W-1:0] idx_t;

  // word indices (byte offset >> 2)
  localparam idx_t IX_REV     = idx_t'(8'h00 >> 2);
  localparam idx_t IX_SYSCFG  = idx_t'(8'h10 >> 2);
  localparam idx_t IX_SYSSTAT = idx_t'(8'h14 >> 2);
  localparam idx_t IX_IRQST   = idx_t'(8'h18 >> 2);
  localparam idx_t IX_IRQEN   = idx_t'(8'h1C >> 2);
  localparam idx_t IX_CTRL    = idx_t'(8'h44 >> 2);
  localparam idx_t IX_FADDR   = idx_t'(8'h48 >> 2);
  localparam idx_t IX_BASE    = idx_t'(8'h4C >> 2);

  // field positions
  localparam int unsigned SC_AUTOIDLE = 0;
  localparam int unsigned SC_SOFT     = 1;
  localparam int unsigned SC_IDLE_LO  = 3;
  localparam int unsigned CT_XLAT     = 1;
  localparam int unsigned CT_WALK     = 2;
  localparam int unsigned CT_EMU      = 3;

  typedef struct packed {
    logic [1:0] idle_mode;
    logic       autoidle;
  } sysconf_t;

  typedef struct packed {
    logic emu_tlb;
    logic walk;
    logic xlat;
  } ctrl_t;
endpackage

// File: rtl/xr_bus_port.sv
module xr_bus_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  output logic          wr_stb,
  output logic          rd_stb,
  input  logic [DW-1:0] rd_word,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  assign req_ready = ~busy;
  assign wr_stb    = req_valid & req_ready & req_write;
  assign rd_stb    = req_valid & req_ready & ~req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_stb;
      if (rd_stb) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/xr_reset_seq.sv
module xr_reset_seq #(
  parameter int unsigned CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b1;
    end else if (start) begin
      cnt_q <= CW'(CYC);
      busy  <= 1'b1;
      done  <= 1'b0;
    end else if (busy) begin
      if (cnt_q == CW'(1)) begin
        cnt_q <= '0;
        busy  <= 1'b0;
        done  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/xr_fault_unit.sv
module xr_fault_unit #(
  parameter int unsigned N    = 5,
  parameter int unsigned VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe,
  input  logic [N-1:0]    pulse,
  input  logic [VA_W-1:0] va,
  input  logic            w1c_stb,
  input  logic [N-1:0]    w1c_mask,
  input  logic            en_stb,
  input  logic [N-1:0]    en_data,
  output logic [N-1:0]    status,
  output logic [N-1:0]    enable,
  output logic [VA_W-1:0] fault_addr,
  output logic            irq
);
  logic [N-1:0] kept;
  logic [N-1:0] hit;
  logic         capture;

  assign kept    = status & ~(w1c_stb ? w1c_mask : '0);
  assign hit     = pulse & enable;
  assign capture = (|hit) && !(|(kept & enable));
  assign irq     = |(status & enable);

  for (genvar i = 0; i < N; i++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    status[i] <= 1'b0;
      else if (wipe) status[i] <= 1'b0;
      else           status[i] <= kept[i] | pulse[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable     <= '0;
      fault_addr <= '0;
    end else if (wipe) begin
      enable     <= '0;
      fault_addr <= '0;
    end else begin
      if (en_stb)  enable     <= en_data;
      if (capture) fault_addr <= va;
    end
  end
endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
  import xr_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned RST_CYCLES = 8,
  parameter int unsigned REV_MAJOR  = 1,
  parameter int unsigned REV_MINOR  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [IDX_W+1:2]     req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [NUM_FAULT-1:0] fault_pulse,
  input  logic [VA_W-1:0]      fault_va,
  output logic                 irq,
  output logic                 xlat_en,
  output logic                 walk_en,
  output logic                 emu_tlb_en,
  output logic [1:0]           idle_mode,
  output logic                 autoidle
);
  localparam logic [DATA_W-1:0] REV_WORD =
    DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)});

  logic                 wr_stb, rd_stb, busy, done, soft_go, wipe;
  logic [DATA_W-1:0]    rd_word;
  logic [NUM_FAULT-1:0] status_w, irq_en_w;
  logic [VA_W-1:0]      fault_addr_w;
  sysconf_t             sc_q;
  ctrl_t                ct_q;
  logic [DATA_W-1:BASE_ALIGN_W] base_q;

  assign soft_go = wr_stb && (req_addr == IX_SYSCFG) && req_wdata[SC_SOFT];
  assign wipe    = soft_go | busy;

  xr_bus_port #(.DW(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_word(rd_word),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  xr_reset_seq #(.CYC(RST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(soft_go), .busy(busy), .done(done)
  );

  xr_fault_unit #(.N(NUM_FAULT), .VA_W(VA_W)) u_fault (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .pulse(fault_pulse), .va(fault_va),
    .w1c_stb(wr_stb && (req_addr == IX_IRQST)),
    .w1c_mask(req_wdata[NUM_FAULT-1:0]),
    .en_stb(wr_stb && (req_addr == IX_IRQEN)),
    .en_data(req_wdata[NUM_FAULT-1:0]),
    .status(status_w), .enable(irq_en_w),
    .fault_addr(fault_addr_w), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q   <= '0;
      ct_q   <= '0;
      base_q <= '0;
    end else if (wipe) begin
      sc_q   <= '0;
      ct_q   <= '0;
      base_q <= '0;
    end else if (wr_stb) begin
      if (req_addr == IX_SYSCFG) begin
        sc_q.idle_mode <= req_wdata[SC_IDLE_LO +: 2];
        sc_q.autoidle  <= req_wdata[SC_AUTOIDLE];
      end
      if (req_addr == IX_CTRL) begin
        ct_q.xlat    <= req_wdata[CT_XLAT];
        ct_q.walk    <= req_wdata[CT_WALK];
        ct_q.emu_tlb <= req_wdata[CT_EMU];
      end
      if ((req_addr == IX_BASE) && (req_wdata[BASE_ALIGN_W-1:0] == '0))
        base_q <= req_wdata[DATA_W-1:BASE_ALIGN_W];
    end
  end

  always_comb begin
    rd_word = '0;
    case (req_addr)
      IX_REV:     rd_word = REV_WORD;
      IX_SYSCFG: begin
        rd_word[SC_IDLE_LO +: 2] = sc_q.idle_mode;
        rd_word[SC_AUTOIDLE]     = sc_q.autoidle;
      end
      IX_SYSSTAT: rd_word[0] = done;
      IX_IRQST:   rd_word[NUM_FAULT-1:0] = status_w;
      IX_IRQEN:   rd_word[NUM_FAULT-1:0] = irq_en_w;
      IX_CTRL: begin
        rd_word[CT_XLAT] = ct_q.xlat;
        rd_word[CT_WALK] = ct_q.walk;
        rd_word[CT_EMU]  = ct_q.emu_tlb;
      end
      IX_FADDR:   rd_word = DATA_W'(fault_addr_w);
      IX_BASE:    rd_word = {base_q, {BASE_ALIGN_W{1'b0}}};
      default:    rd_word = '0;
    endcase
  end

  assign xlat_en    = ct_q.xlat;
  assign walk_en    = ct_q.walk;
  assign emu_tlb_en = ct_q.emu_tlb;
  assign idle_mode  = sc_q.idle_mode;
  assign autoidle   = sc_q.autoidle;
endmodule

// File: rtl/xlat_ctrl_regs_chk.sv
module xlat_ctrl_regs_chk #(
  parameter int unsigned RST_CYCLES = 8,
  parameter int unsigned VA_W       = 32,
  parameter logic [31:0] REV_WORD   = 32'h11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [7:2]      req_addr,
  input logic            soft_bit,
  input logic            rsp_valid,
  input logic [31:0]     rsp_rdata,
  input logic [4:0]      fault_pulse,
  input logic [4:0]      irq_en,
  input logic [4:0]      status,
  input logic [VA_W-1:0] fault_addr,
  input logic            irq,
  input logic            xlat_en,
  input logic            walk_en,
  input logic            emu_tlb_en
);
  localparam int unsigned LW = $clog2(RST_CYCLES + 2) + 1;

  logic          rd_acc, wr_acc;
  logic [LW-1:0] low_cnt;

  assign rd_acc = req_valid && req_ready && !req_write;
  assign wr_acc = req_valid && req_ready && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_cnt <= '0;
    else if (req_ready) low_cnt <= '0;
    else                low_cnt <= low_cnt + LW'(1);
  end

  a_r1_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  a_r1_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);
  a_r2_revision_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && req_addr == 6'h00) |=> (rsp_rdata == REV_WORD));
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !wr_acc) |=> (($past(status) & ~status) == 5'b0));
  a_r7_enabled_fault_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(fault_pulse & irq_en)) && req_ready && !wr_acc) |=> irq);
  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_acc) |=> $stable(fault_addr));
  a_r9_stall_after_soft: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == 6'h04 && soft_bit) |=> !req_ready);
  a_r9_quiet_while_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (!xlat_en && !walk_en && !emu_tlb_en && !irq));
  a_r9_reset_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (low_cnt == LW'(RST_CYCLES)));
endmodule

bind xlat_ctrl_regs xlat_ctrl_regs_chk #(
  .RST_CYCLES(RST_CYCLES), .VA_W(VA_W), .REV_WORD(REV_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .soft_bit(req_wdata[1]),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fault_pulse(fault_pulse),
  .irq_en(irq_en_w), .status(status_w), .fault_addr(fault_addr_w),
  .irq(irq), .xlat_en(xlat_en), .walk_en(walk_en), .emu_tlb_en(emu_tlb_en)
);

// File: tb/xlat_ctrl_regs_tb.sv
module xlat_ctrl_regs_tb;
  localparam int RST_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:2]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [4:0]  fault_pulse = '0;
  logic [31:0] fault_va = '0;
  logic        req_ready, rsp_valid, irq, xlat_en, walk_en, emu_tlb_en, autoidle;
  logic [31:0] rsp_rdata;
  logic [1:0]  idle_mode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xlat_ctrl_regs #(.VA_W(32), .RST_CYCLES(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fault_pulse(fault_pulse),
    .fault_va(fault_va), .irq(irq), .xlat_en(xlat_en), .walk_en(walk_en),
    .emu_tlb_en(emu_tlb_en), .idle_mode(idle_mode), .autoidle(autoidle)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a[7:2]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a[7:2];
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 rsp_valid after read", {31'b0, rsp_valid}, 32'h1);
    d = rsp_rdata;
  endtask

  task automatic pulse(logic [4:0] p, logic [31:0] va);
    @(negedge clk);
    fault_pulse = p; fault_va = va;
    @(negedge clk);
    fault_pulse = '0;
  endtask

  // expected contents after writing 0xFFFFFFF9 to every offset
  function automatic logic [31:0] exp_sweep(int idx);
    case (idx)
      0:  return 32'h11;       // R2
      4:  return 32'h19;       // R3
      5:  return 32'h1;        // R10
      7:  return 32'h19;       // R7
      17: return 32'h8;        // R4
      default: return 32'h0;   // R5 rejected base, R12 unmapped
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 rsp idle at reset", {31'b0, rsp_valid}, 32'h0);
    chk("R9 ready at reset", {31'b0, req_ready}, 32'h1);
    chk("R7 irq low at reset", {31'b0, irq}, 32'h0);
    chk("R4 enables low at reset", {29'b0, emu_tlb_en, walk_en, xlat_en}, 32'h0);
    chk("R3 sysconfig outputs at reset", {29'b0, idle_mode, autoidle}, 32'h0);
    rd(8'h00, d); chk("R2 revision", d, 32'h11);
    rd(8'h14, d); chk("R10 reset done after reset", d, 32'h1);

    // sweep every word of the window
    for (int i = 0; i < 64; i++) wr(8'(i * 4), 32'hFFFF_FFF9);
    for (int i = 0; i < 64; i++) begin
      rd(8'(i * 4), d);
      chk($sformatf("R12 sweep offset %0h", i * 4), d, exp_sweep(i));
    end
    chk("R3 idle/autoidle outputs", {29'b0, idle_mode, autoidle}, 32'h7);
    chk("R4 enable outputs", {29'b0, emu_tlb_en, walk_en, xlat_en}, 32'h4);

    // control register sweep
    for (int v = 0; v < 16; v++) begin
      wr(8'h44, 32'(v));
      rd(8'h44, d); chk("R4 control readback", d, 32'(v) & 32'hE);
      chk("R4 control outputs", {29'b0, emu_tlb_en, walk_en, xlat_en}, 32'(v >> 1) & 32'h7);
    end
    // sysconfig sweep without the reset command
    for (int v = 0; v < 32; v++) begin
      if ((v & 2) != 0) continue;
      wr(8'h10, 32'(v));
      rd(8'h10, d); chk("R3 sysconfig readback", d, 32'(v) & 32'h19);
      chk("R3 sysconfig outputs", {29'b0, idle_mode, autoidle},
          {29'b0, 2'((v >> 3) & 3), 1'(v & 1)});
    end
    // table base alignment
    wr(8'h4C, 32'hABCD_C000); rd(8'h4C, d); chk("R5 aligned base", d, 32'hABCD_C000);
    wr(8'h4C, 32'h1234_5000); rd(8'h4C, d); chk("R5 unaligned rejected", d, 32'hABCD_C000);
    wr(8'h4C, 32'h0000_4001); rd(8'h4C, d); chk("R5 low bit rejected", d, 32'hABCD_C000);
    wr(8'h4C, 32'h0000_4000); rd(8'h4C, d); chk("R5 minimal aligned", d, 32'h0000_4000);

    // enable x source sweep
    wr(8'h18, 32'h1F);
    for (int en = 0; en < 32; en++) begin
      wr(8'h1C, 32'(en));
      for (int s = 0; s < 5; s++) begin
        pulse(5'(1 << s), 32'h1000 * 32'(s + 1));
        chk("R7 irq follows enable", {31'b0, irq}, 32'((en >> s) & 1));
        rd(8'h18, d); chk("R6 status set by pulse", d, 32'(1 << s));
        wr(8'h18, 32'(1 << s));
        rd(8'h18, d); chk("R6 status cleared by one", d, 32'h0);
        chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
      end
    end

    // partial clears
    wr(8'h1C, 32'h1F);
    pulse(5'b10101, 32'h0);
    wr(8'h18, 32'h4); rd(8'h18, d); chk("R6 clear one of three", d, 32'h11);
    wr(8'h18, 32'h0); rd(8'h18, d); chk("R6 zero write no effect", d, 32'h11);
    chk("R7 irq still high", {31'b0, irq}, 32'h1);
    wr(8'h18, d); rd(8'h18, d); chk("R6 write-back clears all", d, 32'h0);
    // same-cycle pulse and clear
    pulse(5'b00001, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h06; req_wdata = 32'h1;
    fault_pulse = 5'b00001;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; fault_pulse = '0;
    rd(8'h18, d); chk("R6 pulse wins over clear", d, 32'h1);
    wr(8'h18, 32'h1F);

    // fault address capture
    pulse(5'b00010, 32'h1111_2000);
    rd(8'h48, d); chk("R8 first fault captured", d, 32'h1111_2000);
    pulse(5'b01000, 32'h2222_3000);
    rd(8'h48, d); chk("R8 later fault ignored", d, 32'h1111_2000);
    wr(8'h18, 32'h1F);
    wr(8'h1C, 32'h1E);
    pulse(5'b00001, 32'h3333_0000);
    chk("R7 disabled source no irq", {31'b0, irq}, 32'h0);
    rd(8'h48, d); chk("R8 disabled source no capture", d, 32'h1111_2000);
    pulse(5'b00100, 32'h4444_0000);
    rd(8'h48, d); chk("R8 capture past disabled pending", d, 32'h4444_0000);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h06; req_wdata = 32'h1F;
    fault_pulse = 5'b10000; fault_va = 32'h5555_0000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; fault_pulse = '0;
    rd(8'h48, d); chk("R8 capture on clearing edge", d, 32'h5555_0000);

    // soft reset with faults arriving while it runs
    wr(8'h44, 32'hE);
    wr(8'h4C, 32'h8000_0000);
    wr(8'h10, 32'h1B);
    begin
      int n = 0;
      while (!req_ready) begin
        n++;
        if (xlat_en || walk_en || emu_tlb_en) begin
          errors++; checks++;
          $display("FAIL R9 enables during reset actual 1 expected 0");
        end
        fault_pulse = 5'h1F;
        @(negedge clk);
      end
      fault_pulse = '0;
      chk("R9 stall length", 32'(n), 32'(RST_CYC));
    end
    rd(8'h10, d); chk("R9 sysconfig cleared", d, 32'h0);
    rd(8'h14, d); chk("R10 done after soft reset", d, 32'h1);
    rd(8'h18, d); chk("R11 faults during reset dropped", d, 32'h0);
    rd(8'h1C, d); chk("R9 enable cleared", d, 32'h0);
    rd(8'h44, d); chk("R9 control cleared", d, 32'h0);
    rd(8'h48, d); chk("R9 fault address cleared", d, 32'h0);
    rd(8'h4C, d); chk("R9 base cleared", d, 32'h0);
    chk("R11 irq low after reset", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'h0); rd(8'h14, d); chk("R10 write ignored", d, 32'h1);
    wr(8'h00, 32'h0); rd(8'h00, d); chk("R2 write ignored", d, 32'h11);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule